// File: doc/BRIEF.md
# LFSR-Addressed Synchronous FIFO

This block is a single-clock first-in first-out buffer. Its write and read locations are not held in binary counters. Each location is held in a linear feedback shift register. Both registers start from the same nonzero seed and use the same feedback taps. They therefore step through an identical pseudo-random order of addresses, and the buffer is still first-in first-out.

With the default 4-bit pointers, a pointer's next state needs one two-input XOR. That puts one gate level in the feedback path. Because the all-zero state is never entered, a pointer of width N reaches 2^N-1 words, so the default buffer holds 15 entries of 4 bits.

A write strobe stores the data bus at the word the write pointer selects and then steps that pointer. A read strobe copies the word at the read pointer into a registered output and then steps that pointer. When the two pointers are equal, a one-bit record of which side moved last tells full from empty.

Top module: `lfsr_fifo`

## Requirements
- R1: While reset is low and on the first cycle after it is released, empty reads 1, full reads 0 and rd_data reads 0.
- R2: Accepted data leaves in the order it was accepted. An accepted read updates rd_data at that clock edge, and rd_data then holds its value until the next accepted read.
- R3: An accepted write makes empty 0 after that clock edge.
- R4: An accepted read makes full 0 after that clock edge.
- R5: Starting from empty, full becomes 1 after the 15th accepted write with no reads. After 14 writes it is still 0.
- R6: A write while full is ignored. The stored contents and the flags are unchanged.
- R7: A read while empty is ignored. rd_data keeps its value and empty stays 1.
- R8: A read and a write in the same cycle, on a buffer that is neither empty nor full, are both performed. Both flags keep their values.
- R9: A read and a write in the same cycle on an empty buffer perform only the write. rd_data is unchanged and empty becomes 0.
- R10: A read and a write in the same cycle on a full buffer perform only the read. full becomes 0 and one entry is free afterwards.
- R11: Both pointers advance by the LFSR step {s[2:0], s[3]^s[2]} from the seed 4'b0001. They never hold zero and return to the seed after 15 steps, and ordering survives repeated wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 4 | Data to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 4 | Registered read data |
| full | output | 1 | No free word remains |
| empty | output | 1 | No stored word remains |

## Verification
A write and a read can fall in the same cycle. How they combine depends on occupancy: both take effect when the buffer is partly filled, only the write takes effect when it is empty, and only the read takes effect when it is full. The bench drives both strobes together in each of these three states. It judges the result against a queue model that first decides which strobes are accepted, from its own count, and then compares rd_data and both flags on the following half cycle. It also drains the buffer afterwards, to confirm that a dropped strobe left no trace in the contents.

// File: rtl/lfsr_fifo.sv
module lfsr_fifo #(
  parameter int DW = 4,
  parameter int PW = 4,
  parameter logic [PW-1:0] TAPS = 4'b1100,
  parameter logic [PW-1:0] SEED = 4'b0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  localparam int WORDS = 2**PW - 1;

  logic [DW-1:0] mem [1:WORDS];
  logic [PW-1:0] wptr, rptr;
  logic          last_wr;
  logic          do_wr, do_rd, same;

  function automatic logic [PW-1:0] lfsr_step(input logic [PW-1:0] s);
    return {s[PW-2:0], ^(s & TAPS)};
  endfunction

  assign same  = (wptr == rptr);
  assign full  = same & last_wr;
  assign empty = same & ~last_wr;
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;

  always_ff @(posedge clk)
    if (do_wr) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr    <= SEED;
      rptr    <= SEED;
      last_wr <= 1'b0;
      rd_data <= '0;
    end else begin
      if (do_wr) wptr <= lfsr_step(wptr);
      if (do_rd) begin
        rd_data <= mem[rptr];
        rptr    <= lfsr_step(rptr);
      end
      if (do_wr != do_rd) last_wr <= do_wr;
    end
endmodule

// File: rtl/lfsr_fifo_chk.sv
module lfsr_fifo_chk #(
  parameter int DW = 4,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          full,
  input logic          empty,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  // R1
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  // R3
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !full) |=> !empty);
  // R4
  read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !empty) |=> !full);
  // R6
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n) (full && wr_en && !rd_en) |=> (full && $stable(wptr)));
  // R7
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n) (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));
  // R8
  both_mid_flags_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && rd_en && !full && !empty) |=> (!full && !empty));
  // R9
  both_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && rd_en && empty) |=> (!empty && $stable(rd_data)));
  // R11
  ptr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) (wptr != '0) && (rptr != '0));
endmodule

bind lfsr_fifo lfsr_fifo_chk #(.DW(DW), .PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .full(full), .empty(empty), .wptr(wptr), .rptr(rptr)
);

// File: tb/lfsr_fifo_test.sv
`timescale 1ns/1ps
module lfsr_fifo_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic full, empty;
  int total = 0, bad = 0;
  logic [3:0] q[$];
  logic [3:0] exp_rd = '0;

  always #2 clk = ~clk;

  lfsr_fifo uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                 .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty));

  task automatic chk(string tag);
    logic ef = (q.size() == 0);
    logic ff = (q.size() == 15);
    total++;
    if (rd_data !== exp_rd || empty !== ef || full !== ff) begin
      bad++;
      $display("FAIL %s: got rd=%h e=%b f=%b exp rd=%h e=%b f=%b",
               tag, rd_data, empty, full, exp_rd, ef, ff);
    end
  endtask

  task automatic step(bit w, logic [3:0] d, bit r, string tag);
    bit aw, ar;
    wr_en = w; wr_data = d; rd_en = r;
    aw = w && q.size() < 15;
    ar = r && q.size() > 0;
    @(posedge clk);
    if (ar) exp_rd = q.pop_front();
    if (aw) q.push_back(d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk(tag);
  endtask

  task automatic drain(string tag);
    while (q.size() > 0) step(0, 4'h0, 1, tag);
  endtask

  task automatic t_reset;
    rst_n = 0;
    q.delete(); exp_rd = '0;
    @(negedge clk); chk("R1 in reset");
    rst_n = 1;
    @(negedge clk); chk("R1 after release");
  endtask

  task automatic t_order;
    for (int i = 0; i < 5; i++) step(1, 4'(i*5+3), 0, "R3 write");
    for (int i = 0; i < 5; i++) step(0, 4'h0, 1, "R2 order");
    step(0, 4'h0, 0, "R2 hold");
  endtask

  task automatic t_fill;
    for (int i = 0; i < 14; i++) step(1, 4'(i*3+1), 0, "R5 below full");
    step(1, 4'hA, 0, "R5 full");
    step(1, 4'h5, 0, "R6 write ignored");
    step(1, 4'h6, 0, "R6 write ignored");
    step(0, 4'h0, 1, "R4 read clears full");
    drain("R6 contents intact");
  endtask

  task automatic t_empty_read;
    step(0, 4'h0, 1, "R7 read ignored");
    step(0, 4'h0, 1, "R7 read ignored");
  endtask

  task automatic t_both;
    step(1, 4'h9, 0, "R3 write");
    step(1, 4'h4, 0, "R3 write");
    for (int i = 0; i < 6; i++) step(1, 4'(i+10), 1, "R8 simultaneous");
    drain("R8 drain");
  endtask

  task automatic t_both_empty;
    step(1, 4'hC, 1, "R9 write only");
    drain("R9 drain");
  endtask

  task automatic t_both_full;
    for (int i = 0; i < 15; i++) step(1, 4'(15-i), 0, "R5 fill");
    step(1, 4'h7, 1, "R10 read only");
    step(1, 4'h8, 0, "R10 one slot free");
    drain("R10 drain");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 40; i++) begin
      step(1, 4'(i*11+2), 0, "R11 wrap write");
      step(1, 4'(i*13+5), 1, "R11 wrap both");
      if (i % 3 == 0) step(0, 4'h0, 1, "R11 wrap read");
    end
    drain("R11 wrap drain");
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_order;
    t_fill;
    t_empty_read;
    t_both;
    t_both_empty;
    t_both_full;
    t_wrap;
    t_reset;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule